// File: doc/BRIEF.md
# Low-Power Mode Command Sequencer

This block walks a processor core, or a shared cache, into a low-power state and back out again. It does this by interpreting a short program of byte commands held in a local sequence memory. Software fills that memory, and the register that names the first command of the selected mode, through a plain write port. When the core reports that it has executed a wait-for-interrupt instruction, the sequencer starts at the stored index. It then fetches and executes one byte after another.

A command byte can do one of four things: drive the seven power-control outputs, insert a programmable delay, stall until the wake interrupt arrives, or end the program. A single memory can hold several modes, each beginning at its own index. A wake interrupt that arrives before the stall command is remembered, so the wake-up half of the program still runs. At the end command the block emits a one-cycle completion pulse and returns to idle.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, `busy` and `wake_done` are low and `pwr_ctrl` is all zeros.
- R2: A write with `cfg_addr` below DEPTH (32) stores `cfg_wdata` as the command byte at that index. A write to address DEPTH stores the low five bits of the data as the start index. A write to any other address changes neither the memory nor the start index.
- R3: A `wfi_req` seen while idle launches execution at the stored start index. `busy` is high from the next cycle up to and including the `wake_done` cycle.
- R4: A byte with bit 7 clear loads its bits [6:0] onto `pwr_ctrl` and takes 2 cycles. `pwr_ctrl` keeps its value under every other command and while idle.
- R5: Byte 8'hC0+n, for n from 0 to 61, delays the program; the command takes n+3 cycles in total.
- R6: Byte 8'hFE stalls the program until `wake_irq` is high. If the interrupt is already present or pending, it takes 2 cycles; otherwise execution resumes one cycle after the cycle in which `wake_irq` is seen.
- R7: A `wake_irq` pulse that arrives while running, before a stall command, is held pending and releases the next stall command without waiting.
- R8: Byte 8'hFF ends the program. It takes 2 cycles, after which `wake_done` is high for exactly one cycle, and in the following cycle `busy` is low. The latency from the launch edge to `wake_done` is 3 cycles plus the cost of every command before the end byte.
- R9: A `wfi_req` that arrives while a program is running is ignored and does not change its timing.
- R10: The command index wraps from DEPTH-1 to 0.
- R11: Bytes 8'h80 to 8'hBF are no-operations that take 2 cycles and leave `pwr_ctrl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration address: 0..31 memory, 32 start index |
| cfg_wdata | input | 8 | Configuration write data |
| wfi_req | input | 1 | Core has executed wait-for-interrupt |
| wake_irq | input | 1 | Wake interrupt |
| pwr_ctrl | output | 7 | Power-control outputs |
| busy | output | 1 | Program running |
| wake_done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default build: a 32-byte memory and a 6-bit delay field. At this size it can sweep every one of the 128 control values and every one of the 62 delay lengths, with the start index moved across the whole memory. Each expected latency comes from the cost formulas in the requirements. Directed programs cover the index wrap, ignored configuration addresses, a long stall, an early wake interrupt held as pending, and a launch request made in the middle of a run.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;
    localparam int CMD_W = 8;
    localparam logic [CMD_W-1:0] OP_WAIT = 8'hFE;
    localparam logic [CMD_W-1:0] OP_END  = 8'hFF;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_EXEC, S_DELAY, S_WAIT_IRQ, S_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        K_CTRL, K_DELAY, K_WAIT, K_END, K_NOP
    } cmd_kind_e;
endpackage

// File: rtl/lpseq_store.sv
module lpseq_store #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [AW:0]                   addr,
    input  logic [lpseq_pkg::CMD_W-1:0]   wdata,
    input  logic [AW-1:0]                 rd_idx,
    output logic [lpseq_pkg::CMD_W-1:0]   rd_byte,
    output logic [AW-1:0]                 start_idx
);
    logic [lpseq_pkg::CMD_W-1:0] mem_q [DEPTH];
    logic [AW-1:0] start_d, start_q;
    logic          hit_start;

    assign hit_start = we && (addr == AW'(0) + (AW+1)'(DEPTH));

    always_comb begin
        start_d = start_q;
        if (hit_start) start_d = wdata[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_q <= '0;
        else        start_q <= start_d;
    end

    always_ff @(posedge clk) begin
        if (we && !addr[AW]) mem_q[addr[AW-1:0]] <= wdata;
    end

    assign rd_byte   = mem_q[rd_idx];
    assign start_idx = start_q;

    // R2: start index changes only through a write to its address
    p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_start |=> $stable(start_idx));
endmodule

// File: rtl/lpseq_decode.sv
module lpseq_decode
    import lpseq_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic [CMD_W-1:0] cmd,
    output cmd_kind_e        kind,
    output logic [CMD_W-2:0] ctrl,
    output logic [DLY_W-1:0] dly
);
    always_comb begin
        ctrl = cmd[CMD_W-2:0];
        dly  = cmd[DLY_W-1:0];
        if (!cmd[CMD_W-1])          kind = K_CTRL;
        else if (cmd == OP_END)     kind = K_END;
        else if (cmd == OP_WAIT)    kind = K_WAIT;
        else if (cmd[CMD_W-2])      kind = K_DELAY;
        else                        kind = K_NOP;
    end
endmodule

// File: rtl/lpseq_fsm.sv
module lpseq_fsm
    import lpseq_pkg::*;
#(
    parameter int AW    = 5,
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_req,
    input  logic             wake_irq,
    input  logic [AW-1:0]    start_idx,
    input  logic [CMD_W-1:0] rd_byte,
    input  cmd_kind_e        kind,
    input  logic [CMD_W-2:0] ctrl,
    input  logic [DLY_W-1:0] dly,
    output logic [AW-1:0]    rd_idx,
    output logic [CMD_W-1:0] cmd,
    output logic [CMD_W-2:0] pwr_ctrl,
    output logic             busy,
    output logic             wake_done
);
    typedef struct packed {
        seq_state_e       state;
        logic [AW-1:0]    pc;
        logic [CMD_W-1:0] cmd;
        logic [DLY_W-1:0] cnt;
        logic [CMD_W-2:0] ctrl;
        logic             pend;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      irq_avail;

    assign irq_avail = wake_irq || r_q.pend;

    always_comb begin
        r_d = r_q;
        if (r_q.state != S_IDLE && wake_irq) r_d.pend = 1'b1;
        unique case (r_q.state)
            S_IDLE: begin
                r_d.pend = 1'b0;
                if (wfi_req) begin
                    r_d.pc    = start_idx;
                    r_d.state = S_FETCH;
                end
            end
            S_FETCH: begin
                r_d.cmd   = rd_byte;
                r_d.state = S_EXEC;
            end
            S_EXEC: begin
                unique case (kind)
                    K_CTRL: begin
                        r_d.ctrl  = ctrl;
                        r_d.pc    = r_q.pc + 1'b1;
                        r_d.state = S_FETCH;
                    end
                    K_DELAY: begin
                        r_d.cnt   = dly;
                        r_d.state = S_DELAY;
                    end
                    K_WAIT: begin
                        if (irq_avail) begin
                            r_d.pend  = 1'b0;
                            r_d.pc    = r_q.pc + 1'b1;
                            r_d.state = S_FETCH;
                        end else begin
                            r_d.state = S_WAIT_IRQ;
                        end
                    end
                    K_END: r_d.state = S_DONE;
                    default: begin
                        r_d.pc    = r_q.pc + 1'b1;
                        r_d.state = S_FETCH;
                    end
                endcase
            end
            S_DELAY: begin
                if (r_q.cnt == '0) begin
                    r_d.pc    = r_q.pc + 1'b1;
                    r_d.state = S_FETCH;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            S_WAIT_IRQ: begin
                if (irq_avail) begin
                    r_d.pend  = 1'b0;
                    r_d.pc    = r_q.pc + 1'b1;
                    r_d.state = S_FETCH;
                end
            end
            S_DONE:  r_d.state = S_IDLE;
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, pc: '0, cmd: '0, cnt: '0, ctrl: '0, pend: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_idx    = r_q.pc;
    assign cmd       = r_q.cmd;
    assign pwr_ctrl  = r_q.ctrl;
    assign busy      = (r_q.state != S_IDLE);
    assign wake_done = (r_q.state == S_DONE);

    // R3: a request while idle launches the program
    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wfi_req) |=> busy);
    // R8: completion is a single-cycle pulse followed by idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> (!wake_done && !busy));
    // R4: outputs move only when a control byte executes
    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.state == S_EXEC && kind == K_CTRL) |=> $stable(pwr_ctrl));
    // R6: stall persists while no interrupt is present or pending
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_WAIT_IRQ && !wake_irq && !r_q.pend) |=> (r_q.state == S_WAIT_IRQ));
    // R7: an interrupt while running is remembered
    p_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wake_done && wake_irq && r_q.state != S_EXEC && r_q.state != S_WAIT_IRQ)
        |=> r_q.pend);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpseq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int DLY_W = 6,
    localparam int CTRL_W = CMD_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW:0]       cfg_addr,
    input  logic [CMD_W-1:0]  cfg_wdata,
    input  logic              wfi_req,
    input  logic              wake_irq,
    output logic [CTRL_W-1:0] pwr_ctrl,
    output logic              busy,
    output logic              wake_done
);
    logic [AW-1:0]     rd_idx, start_idx;
    logic [CMD_W-1:0]  rd_byte, cmd;
    cmd_kind_e         kind;
    logic [CTRL_W-1:0] ctrl;
    logic [DLY_W-1:0]  dly;

    lpseq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rd_idx(rd_idx), .rd_byte(rd_byte), .start_idx(start_idx)
    );

    lpseq_decode #(.DLY_W(DLY_W)) u_decode (
        .cmd(cmd), .kind(kind), .ctrl(ctrl), .dly(dly)
    );

    lpseq_fsm #(.AW(AW), .DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wake_irq(wake_irq),
        .start_idx(start_idx), .rd_byte(rd_byte), .kind(kind), .ctrl(ctrl), .dly(dly),
        .rd_idx(rd_idx), .cmd(cmd), .pwr_ctrl(pwr_ctrl), .busy(busy), .wake_done(wake_done)
    );
endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       wfi_req = 1'b0;
    logic       wake_irq = 1'b0;
    logic [6:0] pwr_ctrl;
    logic       busy, wake_done;
    int         n_chk = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    lpm_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wfi_req(wfi_req), .wake_irq(wake_irq),
        .pwr_ctrl(pwr_ctrl), .busy(busy), .wake_done(wake_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Launch; return edges from launch edge until wake_done is seen.
    task automatic run(input int irq_at, input int wfi_at, output int lat);
        @(negedge clk);
        wfi_req = 1'b1;
        @(negedge clk);
        wfi_req = 1'b0;
        lat = 1;
        while (!wake_done && lat < 2000) begin
            wake_irq = (lat == irq_at);
            wfi_req  = (lat == wfi_at);
            @(negedge clk);
            lat++;
        end
        wake_irq = 1'b0;
        wfi_req  = 1'b0;
        check("R8 pulse", int'(wake_done), 1);
        @(negedge clk);
        check("R8 idle after pulse", int'({busy, wake_done}), 0);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat;
        #1;
        check("R1 busy", int'(busy), 0);
        check("R1 wake_done", int'(wake_done), 0);
        check("R1 pwr_ctrl", int'(pwr_ctrl), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 busy after release", int'(busy), 0);

        // R4/R3/R2: every control value, start index across the memory
        for (int v = 0; v < 128; v++) begin
            int s;
            s = (v * 7) % 32;
            wr(s, v);
            wr((s + 1) % 32, 8'hFF);
            wr(32, s);
            run(-1, -1, lat);
            check("R4 control latency", lat, 5);
            check("R4 control value", int'(pwr_ctrl), v);
        end

        // R5: every delay length
        for (int n = 0; n < 62; n++) begin
            int s;
            s = (n * 3) % 32;
            wr(s, 8'hC0 + n);
            wr((s + 1) % 32, 8'hFF);
            wr(32, s);
            run(-1, -1, lat);
            check("R5 delay latency", lat, n + 6);
        end
        check("R4 held under delay", int'(pwr_ctrl), 127);

        // R10: wrap from last index to 0
        wr(31, 8'h15); wr(0, 8'h6A); wr(1, 8'hFF); wr(32, 31);
        run(-1, -1, lat);
        check("R10 wrap latency", lat, 7);
        check("R10 wrap value", int'(pwr_ctrl), 8'h6A);

        // R2: addresses above the start register are ignored
        wr(1, 8'h2A); wr(2, 8'hFF); wr(32, 1);
        wr(33, 8'hFF); wr(34, 8'h00); wr(63, 8'h05);
        run(-1, -1, lat);
        check("R2 ignored addr latency", lat, 5);
        check("R2 ignored addr value", int'(pwr_ctrl), 8'h2A);

        // R11: no-op bytes
        wr(4, 8'h80); wr(5, 8'hBF); wr(6, 8'hFF); wr(32, 4);
        run(-1, -1, lat);
        check("R11 nop latency", lat, 7);
        check("R11 nop keeps outputs", int'(pwr_ctrl), 8'h2A);

        // R6: stall until the interrupt
        wr(8, 8'h11); wr(9, 8'hFE); wr(10, 8'h22); wr(11, 8'hFF); wr(32, 8);
        run(40, -1, lat);
        check("R6 stall latency", lat, 45);
        check("R6 after wake value", int'(pwr_ctrl), 8'h22);

        // R7: interrupt during a delay is held pending
        wr(12, 8'hCA); wr(13, 8'hFE); wr(14, 8'hFF); wr(32, 12);
        run(3, -1, lat);
        check("R7 pending latency", lat, 18);

        // R6: interrupt present when the stall executes
        run(14, -1, lat);
        check("R6 immediate latency", lat, 18);

        // R9: launch request mid-run ignored
        run(3, 6, lat);
        check("R9 timing unchanged", lat, 18);
        repeat (3) @(negedge clk);
        check("R9 no relaunch", int'(busy), 0);

        // R3: busy throughout a run
        @(negedge clk); wfi_req = 1'b1;
        @(negedge clk); wfi_req = 1'b0;
        check("R3 busy after launch", int'(busy), 1);
        wake_irq = 1'b1;
        repeat (5) @(negedge clk);
        check("R3 busy mid-run", int'(busy), 1);
        wake_irq = 1'b0;
        while (!wake_done) @(negedge clk);
        check("R3 busy at done", int'(busy), 1);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule